// File: doc/BRIEF.md
# Divider Setting Loader

This block holds the setting for a clock synthesizer's dividers. The setting is a 9-bit feedback divide value and a 2-bit output divider code, and the block also decodes that code into an actual divide ratio. A setting can reach the block in two ways. The first is a parallel word on pins, taken under an active-low strobe. The strobe is transparent while low and captures the word when it rises. The second is a three-wire serial port: a serial clock, a serial data bit, and an apply strobe. While the apply strobe is high, the shifted frame is shown on the outputs, and the falling edge of the apply strobe makes that frame the held setting.

All control and data inputs are treated as asynchronous. Each passes through a two-flop synchronizer into the system clock domain, and edges are detected there. The active setting and a diagnostic output are registered, so a setting change appears three system clocks after the input change. An asynchronous, active-high hard reset mutes the downstream clocks and restores a default setting.

A diagnostic mode routes raw serial data to the diagnostic output for the feedback path. In this mode the held setting is left alone.

Top module: `divset_loader`

## Requirements
- R1: While `hard_rst` is high, `clk_mute` is 1, `fb_div` is 25, `od_code` is 01 and `diag_out` is 0, and the serial frame is cleared to zero. `clk_mute` falls on the second rising clock edge after `hard_rst` falls.
- R2: While `par_strobe_n` is low, `fb_div` and `od_code` follow `fb_pin` and `od_pin`, three clocks after any change, and `diag_out` is 0. This holds whatever the serial inputs do.
- R3: A rising edge on `par_strobe_n` captures `fb_pin` and `od_pin` as the held setting. The held setting is shown from then on.
- R4: With `par_strobe_n` high and `ser_apply` low, each rising edge of `ser_clk` shifts `ser_dat` into an 11-bit frame. The frame is sent N1 first, then N0, then feedback bits 8 down to 0. When the frame is complete, the code sits in the top two bits and the feedback value in the low nine bits. Only the last 11 bits are kept. A `ser_clk` edge while `ser_apply` is high shifts nothing.
- R5: While `par_strobe_n` is high, `ser_apply` is high and `diag_en` is low, `fb_div` and `od_code` show the frame contents.
- R6: A falling edge of `ser_apply` with `par_strobe_n` high and `diag_en` low makes the frame the held setting. This replaces any setting captured from the pins.
- R7: With `par_strobe_n` high and `ser_apply` low, changes on `fb_pin`, `od_pin`, `ser_dat` and `ser_clk` leave `fb_div` and `od_code` unchanged.
- R8: `od_ratio` equals the divide ratio for `od_code`: 00 gives 3, 01 gives 4, 10 gives 5, 11 gives 6.
- R9: With `par_strobe_n`, `ser_apply` and `diag_en` all high, `diag_out` takes `ser_dat` on each `ser_clk` rising edge and the held setting is shown. A fall of `ser_apply` in this mode does not latch the frame. `diag_out` is 0 whenever this mode is not in effect.
- R10: If a rise of `par_strobe_n` and a fall of `ser_apply` (with `diag_en` low) reach the block in the same cycle, the frame becomes the held setting and the pins are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hard_rst | input | 1 | Asynchronous active-high reset |
| par_strobe_n | input | 1 | Parallel strobe: transparent when low, captures on rise |
| fb_pin | input | 9 | Parallel feedback divide value |
| od_pin | input | 2 | Parallel output divider code |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data bit |
| ser_apply | input | 1 | Serial apply strobe: shows frame when high, latches on fall |
| diag_en | input | 1 | Diagnostic mode enable |
| fb_div | output | 9 | Active feedback divide value |
| od_code | output | 2 | Active output divider code |
| od_ratio | output | 3 | Decoded output divide ratio |
| diag_out | output | 1 | Diagnostic serial pass-through |
| clk_mute | output | 1 | High while downstream clocks must be held low |

## Verification
Two load functions can fall in the same cycle: the parallel strobe rising and the serial apply falling. The bench provokes this by changing both inputs on the same falling clock edge. Because the two inputs pass through identical synchronizers, they arrive as edges in one cycle, and the check expects the shifted frame, not the pin word, as the held setting. A related overlap is also tested: serial apply held high while the parallel strobe is low. Here the pins must be shown, and the frame must take over only once the strobe rises.

// File: rtl/divset_pkg.sv
package divset_pkg;
  localparam int FB_W     = 9;   // feedback divide value width
  localparam int OD_W     = 2;   // output divider code width
  localparam int OD_BASE  = 3;   // ratio of code zero
  localparam int FB_DEF   = 25;  // feedback value after reset
  localparam int OD_DEF   = 1;   // divider code after reset

  // Divide ratio selected by an output divider code.
  function automatic int od_ratio_of(input int code, input int base);
    return base + code;
  endfunction
endpackage

// File: rtl/divset_rst_sync.sv
module divset_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic hard_rst,
  output logic rst,
  output logic clk_mute
);
  logic [STAGES-1:0] st;

  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst) st <= '1;
    else          st <= {st[STAGES-2:0], 1'b0};
  end

  assign rst      = st[STAGES-1];
  assign clk_mute = st[STAGES-1];

  AST_MUTE_ON_RESET: assert property (@(posedge clk) hard_rst |-> clk_mute); // R1
endmodule

// File: rtl/divset_sync.sv
module divset_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/divset_shreg.sv
module divset_shreg #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         shift_bit,
  output logic [W-1:0] frame
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)           frame <= '0;
    else if (shift_en) frame <= {frame[W-2:0], shift_bit};
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> frame[0] == $past(shift_bit) && frame[W-1:1] == $past(frame[W-2:0])); // R4
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(frame)); // R4
endmodule

// File: rtl/divset_ctrl.sv
module divset_ctrl #(
  parameter int M_W   = 9,
  parameter int N_W   = 2,
  parameter int M_RST = 25,
  parameter int N_RST = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pl_n,
  input  logic             sl,
  input  logic             sc,
  input  logic             sd,
  input  logic             tst,
  input  logic [M_W-1:0]   fb_s,
  input  logic [N_W-1:0]   od_s,
  input  logic [M_W+N_W-1:0] frame,
  output logic             shift_en,
  output logic             shift_bit,
  output logic [M_W-1:0]   fb_div,
  output logic [N_W-1:0]   od_code,
  output logic             diag_out
);
  localparam int F_W = M_W + N_W;
  localparam logic [F_W-1:0] DEF = {N_W'(N_RST), M_W'(M_RST)};

  logic pl_q, sl_q, sc_q;
  logic pl_rise, sl_fall, sc_rise;
  logic diag_mode, ser_take;
  logic [F_W-1:0] held, held_d, sel;
  logic diag_d;

  // Edge history of the synchronized strobes.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pl_q <= 1'b1;
      sl_q <= 1'b0;
      sc_q <= 1'b0;
    end else begin
      pl_q <= pl_n;
      sl_q <= sl;
      sc_q <= sc;
    end
  end

  assign pl_rise   = pl_n & ~pl_q;
  assign sl_fall   = sl_q & ~sl;
  assign sc_rise   = sc & ~sc_q;
  assign diag_mode = pl_n & sl & tst;
  assign ser_take  = pl_n & sl_fall & ~tst;
  assign shift_en  = pl_n & ~sl & sc_rise;
  assign shift_bit = sd;

  // Held setting: a serial apply outranks a parallel capture.
  always_comb begin
    held_d = held;
    if (ser_take)     held_d = frame;
    else if (pl_rise) held_d = {od_s, fb_s};
  end

  always_comb begin
    if (!pl_n)          sel = {od_s, fb_s};
    else if (sl & ~tst) sel = frame;
    else                sel = held_d;
  end

  always_comb begin
    if (!diag_mode)   diag_d = 1'b0;
    else if (sc_rise) diag_d = sd;
    else              diag_d = diag_out;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      held              <= DEF;
      {od_code, fb_div} <= DEF;
      diag_out          <= 1'b0;
    end else begin
      held              <= held_d;
      {od_code, fb_div} <= sel;
      diag_out          <= diag_d;
    end
  end

  AST_PAR_PASS: assert property (@(posedge clk) disable iff (rst)
    !pl_n |=> fb_div == $past(fb_s) && od_code == $past(od_s) && !diag_out); // R2
  AST_PAR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    pl_rise && !ser_take |=> held == $past({od_s, fb_s})); // R3
  AST_SER_VIEW: assert property (@(posedge clk) disable iff (rst)
    pl_n && sl && !tst |=> {od_code, fb_div} == $past(frame)); // R5
  AST_SER_LATCH: assert property (@(posedge clk) disable iff (rst)
    ser_take |=> held == $past(frame)); // R6
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    pl_n && !sl && !sl_fall && !pl_rise |=> $stable(held) && {od_code, fb_div} == $past(held)); // R7
  AST_DIAG_QUIET: assert property (@(posedge clk) disable iff (rst)
    !diag_mode |=> !diag_out); // R9
  AST_DIAG_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
    pl_n && sl_fall && tst && !pl_rise |=> $stable(held)); // R9
  AST_SER_WINS: assert property (@(posedge clk) disable iff (rst)
    pl_rise && ser_take |=> held == $past(frame)); // R10
endmodule

// File: rtl/divset_loader.sv
module divset_loader #(
  parameter int M_W    = divset_pkg::FB_W,
  parameter int N_W    = divset_pkg::OD_W,
  parameter int N_BASE = divset_pkg::OD_BASE,
  parameter int M_RST  = divset_pkg::FB_DEF,
  parameter int N_RST  = divset_pkg::OD_DEF
) (
  input  logic           clk,
  input  logic           hard_rst,
  input  logic           par_strobe_n,
  input  logic [M_W-1:0] fb_pin,
  input  logic [N_W-1:0] od_pin,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_apply,
  input  logic           diag_en,
  output logic [M_W-1:0] fb_div,
  output logic [N_W-1:0] od_code,
  output logic [$clog2(N_BASE + (1 << N_W))-1:0] od_ratio,
  output logic           diag_out,
  output logic           clk_mute
);
  localparam int R_W = $clog2(N_BASE + (1 << N_W));
  localparam int F_W = M_W + N_W;

  logic rst;
  logic pl_s;
  logic [3:0] ctl_s;
  logic [F_W-1:0] word_s;
  logic [F_W-1:0] frame;
  logic shift_en, shift_bit;

  divset_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .hard_rst(hard_rst), .rst(rst), .clk_mute(clk_mute)
  );

  // Strobe idles high, so its synchronizer resets high.
  divset_sync #(.W(1), .RST_VAL(1'b1)) u_sync_pl (
    .clk(clk), .rst(rst), .d(par_strobe_n), .q(pl_s)
  );
  divset_sync #(.W(4), .RST_VAL(4'b0)) u_sync_ctl (
    .clk(clk), .rst(rst), .d({ser_apply, ser_clk, ser_dat, diag_en}), .q(ctl_s)
  );
  divset_sync #(.W(F_W), .RST_VAL('0)) u_sync_word (
    .clk(clk), .rst(rst), .d({od_pin, fb_pin}), .q(word_s)
  );

  divset_shreg #(.W(F_W)) u_shreg (
    .clk(clk), .rst(rst), .shift_en(shift_en), .shift_bit(shift_bit), .frame(frame)
  );

  divset_ctrl #(.M_W(M_W), .N_W(N_W), .M_RST(M_RST), .N_RST(N_RST)) u_ctrl (
    .clk(clk), .rst(rst), .pl_n(pl_s),
    .sl(ctl_s[3]), .sc(ctl_s[2]), .sd(ctl_s[1]), .tst(ctl_s[0]),
    .fb_s(word_s[M_W-1:0]), .od_s(word_s[F_W-1:M_W]), .frame(frame),
    .shift_en(shift_en), .shift_bit(shift_bit),
    .fb_div(fb_div), .od_code(od_code), .diag_out(diag_out)
  );

  assign od_ratio = R_W'(divset_pkg::od_ratio_of(int'(od_code), N_BASE));

  AST_RESET_VALUES: assert property (@(posedge clk)
    hard_rst |-> int'(fb_div) == M_RST && int'(od_code) == N_RST && !diag_out); // R1
  AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (hard_rst)
    int'(od_ratio) >= N_BASE && int'(od_ratio) < N_BASE + (1 << N_W)); // R8
endmodule

// File: tb/tb_divset_loader.sv
module tb_divset_loader;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic hard_rst, par_strobe_n, ser_clk, ser_dat, ser_apply, diag_en;
  logic [8:0] fb_pin;
  logic [1:0] od_pin;
  logic [8:0] fb_div;
  logic [1:0] od_code;
  logic [2:0] od_ratio;
  logic diag_out, clk_mute;

  divset_loader dut (
    .clk(clk), .hard_rst(hard_rst), .par_strobe_n(par_strobe_n),
    .fb_pin(fb_pin), .od_pin(od_pin), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_apply(ser_apply), .diag_en(diag_en), .fb_div(fb_div), .od_code(od_code),
    .od_ratio(od_ratio), .diag_out(diag_out), .clk_mute(clk_mute)
  );

  always #(CLK_PER/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  int settle = 0;
  bit chk_on = 0;
  string cur_req = "R1";

  // Reference model state
  int e_fb = 25, e_od = 1, e_dg = 0;
  int h_fb = 25, h_od = 1;
  bit bits_q[$];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int frame_val();
    int acc = 0;
    foreach (bits_q[i]) acc = (acc * 2 + int'(bits_q[i])) % 2048;
    return acc;
  endfunction

  // Compare every clock once the last stimulus has settled.
  always @(posedge clk) begin
    #(CLK_PER/4);
    settle++;
    if (chk_on && settle >= 4) begin
      check(cur_req, "fb_div", int'(fb_div), e_fb);
      check(cur_req, "od_code", int'(od_code), e_od);
      check(cur_req, "diag_out", int'(diag_out), e_dg);
      check("R8", "od_ratio", int'(od_ratio), e_od + 3);
      check("R1", "clk_mute", int'(clk_mute), 0);
    end
  end

  task automatic drv(input logic npl, input logic nsl, input logic nsc, input logic nsd,
                     input logic ntst, input int nm, input int nn);
    bit pr, sf, cr;
    int fv;
    @(negedge clk);
    pr = !par_strobe_n && npl;
    sf = ser_apply && !nsl;
    cr = !ser_clk && nsc;
    par_strobe_n = npl; ser_apply = nsl; ser_clk = nsc; ser_dat = nsd; diag_en = ntst;
    fb_pin = nm[8:0]; od_pin = nn[1:0];
    if (!npl) begin
      e_fb = nm; e_od = nn; e_dg = 0;
    end else begin
      fv = frame_val();
      if (sf && !ntst) begin h_fb = fv % 512; h_od = fv / 512; end
      else if (pr)     begin h_fb = nm; h_od = nn; end
      if (!nsl && cr) begin
        bits_q.push_back(nsd);
        if (bits_q.size() > 11) void'(bits_q.pop_front());
      end
      if (nsl && ntst) begin
        if (cr) e_dg = int'(nsd);
      end else e_dg = 0;
      fv = frame_val();
      if (nsl && !ntst) begin e_fb = fv % 512; e_od = fv / 512; end
      else              begin e_fb = h_fb;     e_od = h_od;     end
    end
    settle = 0;
    repeat (6) @(negedge clk);
  endtask

  // Short-hands keeping other inputs at their present values
  task automatic set_sd(input logic b);
    drv(par_strobe_n, ser_apply, ser_clk, b, diag_en, int'(fb_pin), int'(od_pin));
  endtask
  task automatic pulse_sc();
    drv(par_strobe_n, ser_apply, 1'b1, ser_dat, diag_en, int'(fb_pin), int'(od_pin));
    drv(par_strobe_n, ser_apply, 1'b0, ser_dat, diag_en, int'(fb_pin), int'(od_pin));
  endtask
  task automatic set_apply(input logic b);
    drv(par_strobe_n, b, ser_clk, ser_dat, diag_en, int'(fb_pin), int'(od_pin));
  endtask
  task automatic send_frame(input int n, input int m);
    int word = n * 512 + m;
    for (int b = 10; b >= 0; b--) begin
      set_sd(logic'((word >> b) & 1));
      pulse_sc();
    end
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    hard_rst = 1'b1; par_strobe_n = 1'b1; ser_clk = 1'b0; ser_dat = 1'b0;
    ser_apply = 1'b0; diag_en = 1'b0; fb_pin = '0; od_pin = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "clk_mute in reset", int'(clk_mute), 1);
    check("R1", "fb_div in reset", int'(fb_div), 25);
    check("R1", "od_code in reset", int'(od_code), 1);
    check("R1", "diag_out in reset", int'(diag_out), 0);
    check("R8", "od_ratio in reset", int'(od_ratio), 4);
    hard_rst = 1'b0;
    @(posedge clk); #(CLK_PER/4);
    check("R1", "clk_mute one edge after release", int'(clk_mute), 1);
    @(posedge clk); #(CLK_PER/4);
    check("R1", "clk_mute two edges after release", int'(clk_mute), 0);
    repeat (3) @(negedge clk);
    settle = 0; chk_on = 1;

    // R2: transparent parallel load
    cur_req = "R2";
    drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 100, 2);
    drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 300, 3);
    drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 28, 1);
    // R3: capture on strobe rise, then pins ignored (R7)
    cur_req = "R3";
    drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 28, 1);
    check("R3", "captured fb_div", int'(fb_div), 28);
    cur_req = "R7";
    drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 7, 3);
    check("R7", "fb_div after pin change", int'(fb_div), 28);

    // R4: shift a frame (held setting unchanged meanwhile, R7)
    cur_req = "R4";
    send_frame(2, 31);
    check("R7", "fb_div during shifting", int'(fb_div), 28);
    // R5: frame shown while apply high; clock edges do not shift
    cur_req = "R5";
    set_apply(1'b1);
    check("R5", "fb_div shows frame", int'(fb_div), 31);
    check("R5", "od_code shows frame", int'(od_code), 2);
    set_sd(1'b1);
    pulse_sc();
    check("R4", "no shift while apply high", int'(fb_div), 31);
    // R6: latch on apply fall
    cur_req = "R6";
    set_apply(1'b0);
    check("R6", "latched fb_div", int'(fb_div), 31);
    check("R6", "latched od_code", int'(od_code), 2);
    // R7: serial and pin activity after latch leaves setting alone
    cur_req = "R7";
    set_sd(1'b0); pulse_sc(); set_sd(1'b1); pulse_sc();
    drv(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 400, 0);
    check("R7", "fb_div after activity", int'(fb_div), 31);

    // R3: parallel load after serial
    cur_req = "R3";
    drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 50, 0);
    drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 50, 0);
    check("R3", "fb_div after reload", int'(fb_div), 50);

    // R8: every divider code
    cur_req = "R8";
    for (int c = 0; c < 4; c++) begin
      drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 50, c);
      check("R8", "od_ratio per code", int'(od_ratio), c + 3);
    end
    drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 50, 3);

    // R9: diagnostic pass-through
    cur_req = "R9";
    drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 50, 3);
    set_apply(1'b1);
    check("R9", "held shown in diag mode", int'(fb_div), 50);
    set_sd(1'b1); pulse_sc();
    check("R9", "diag_out takes 1", int'(diag_out), 1);
    set_sd(1'b0); pulse_sc();
    check("R9", "diag_out takes 0", int'(diag_out), 0);
    set_sd(1'b1); pulse_sc();
    set_apply(1'b0);
    check("R9", "no latch on fall in diag mode", int'(fb_div), 50);
    check("R9", "diag_out low outside mode", int'(diag_out), 0);
    drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 50, 3);

    // R10: coincident strobe rise and apply fall
    cur_req = "R10";
    send_frame(3, 77);
    set_apply(1'b1);
    drv(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 200, 0);
    check("R10", "pins win while strobe low", int'(fb_div), 200);
    drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 200, 0);
    check("R10", "frame wins on coincidence", int'(fb_div), 77);
    check("R10", "frame code wins", int'(od_code), 3);

    // R1: reset in mid-run
    cur_req = "R1";
    @(negedge clk);
    chk_on = 0;
    hard_rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "clk_mute mid-run", int'(clk_mute), 1);
    check("R1", "fb_div mid-run reset", int'(fb_div), 25);
    check("R1", "od_code mid-run reset", int'(od_code), 1);
    hard_rst = 1'b0;
    h_fb = 25; h_od = 1; e_fb = 25; e_od = 1; e_dg = 0;
    bits_q.delete();
    repeat (6) @(negedge clk);
    settle = 0; chk_on = 1;
    set_apply(1'b1);
    check("R1", "frame cleared by reset", int'(fb_div), 0);
    set_apply(1'b0);
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule